// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block is a master-side loader. It writes a volatile configuration image into an FPGA that takes its configuration as an SPI slave. On a start pulse it pulls the target's active-low reset and its chip select low together and holds both for a fixed time. It then releases the reset and checks that the target's configuration-done line reads low, which shows that the target really reset. It waits out the target's housekeeping period with chip select still low, and then releases chip select for one cycle.

Next it streams the image bytes, which the host presents on a valid/ready byte interface with a last-byte marker. The bytes go out in SPI mode 0, most significant bit first. After the last byte it releases chip select and samples the done line again. If the line is high, the block clocks out seven zero bytes. This gives 56 clocks, at least the 49 the target needs to start the loaded design. Only then does it report success.

All wait times are cycle counts. They are derived from the system clock frequency parameter and rounded up. The serial clock is the system clock divided by twice `SCK_DIV`. A configuration whose serial clock falls outside 1 MHz to 25 MHz is rejected at elaboration.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After an accepted start, `tgt_rst_n_o` and `tgt_cs_n_o` go low on the same clock edge. The reset stays low for exactly RST_CYC = ceil(CLK_HZ × RST_HOLD_NS / 1e9) cycles. Chip select is low in every cycle in which the reset is low, and it stays low when the reset rises.
- R2: One cycle after the reset is released, `tgt_done_i` is sampled. If it is high, `err_o` is set, `busy_o` drops, chip select goes high and no serial clock is ever produced for that run.
- R3: After the reset rises, chip select stays low for exactly HK_CYC + 1 cycles, where HK_CYC = ceil(CLK_HZ × HK_US / 1e6). That is one check cycle plus the housekeeping wait. Chip select is then high for one cycle and goes low again for the stream.
- R4: Serial clock: mode 0, idle low, low whenever chip select is high. `mosi_o` does not change at a rising `sck_o` edge. The bits of each byte appear on the rising edges most significant bit first.
- R5: A byte is taken only in a cycle where `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is low outside the streaming phase, including during reset and housekeeping. It is low in the cycle after every accepted byte. The bytes go out in the order they were accepted.
- R6: After the byte marked by `s_last_i` has been shifted, chip select goes high and `tgt_done_i` is sampled. If it is low, `err_o` is set and no activation clocks are sent.
- R7: If `tgt_done_i` is high after the stream, exactly 7 bytes of value 0x00 are clocked out with chip select low, which is 56 rising edges with `mosi_o` low. After that `done_o` is set and chip select goes high.
- R8: A start with `partial_i` high sets `err_o` on the next cycle. It leaves `tgt_rst_n_o` and `tgt_cs_n_o` high and keeps `busy_o` low.
- R9: `done_o` and `err_o` are never both high and stay set until the next accepted start. A start clears both, and `busy_o` is high from the cycle after it until one of them is set. A start while busy is ignored.
- R10: After system reset, `tgt_rst_n_o` and `tgt_cs_n_o` are 1, and `sck_o`, `mosi_o`, `s_ready_o`, `busy_o`, `done_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start_i | input | 1 | Begin a load (taken only while not busy) |
| partial_i | input | 1 | Start request is a partial reconfiguration; rejected |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Marks the final image byte |
| s_ready_o | output | 1 | Block can take an image byte |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Load and activation finished successfully |
| err_o | output | 1 | Load failed or request rejected |
| tgt_rst_n_o | output | 1 | Target reset, active low |
| tgt_cs_n_o | output | 1 | Target chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to target |
| tgt_done_i | input | 1 | Target configuration-done line |

## Verification
Two pairs of events can land in the same cycle. The first is a host byte already waiting with valid held high while the shifter is finishing the previous byte. The second is a fresh start pulse arriving while a load is in progress. The bench drives one image with valid held high back to back, so the next byte is offered at the very cycle the previous one finishes. It judges the case by the captured serial bytes and their order and by ready being low after each acceptance. It also raises start in the middle of housekeeping and confirms that the reset and housekeeping windows still measure their exact cycle counts and that busy never drops.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_CHK,
        ST_HK,
        ST_GAP,
        ST_STRM,
        ST_POST,
        ST_PAD
    } seq_state_e;

    function automatic longint ceil_div(input longint num, input longint den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cfg_spi_shifter.sv
module cfg_spi_shifter #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] data_i,
    output logic       busy_o,
    output logic       fin_o,
    output logic       sck_o,
    output logic       mosi_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic [7:0]    sh;
        logic [2:0]    bits;
        logic [DW-1:0] div;
    } shift_t;

    shift_t sh_d, sh_q;
    logic   fin_c;

    always_comb begin
        sh_d  = sh_q;
        fin_c = 1'b0;
        if (!sh_q.busy) begin
            if (load_i) begin
                sh_d.busy = 1'b1;
                sh_d.sh   = data_i;
                sh_d.bits = '0;
                sh_d.div  = '0;
                sh_d.sck  = 1'b0;
            end
        end else if (sh_q.div == DW'(DIV - 1)) begin
            sh_d.div = '0;
            if (!sh_q.sck) begin
                sh_d.sck = 1'b1;
            end else begin
                sh_d.sck = 1'b0;
                if (sh_q.bits == 3'd7) begin
                    sh_d.busy = 1'b0;
                    fin_c     = 1'b1;
                end else begin
                    sh_d.bits = sh_q.bits + 3'd1;
                    sh_d.sh   = {sh_q.sh[6:0], 1'b0};
                end
            end
        end else begin
            sh_d.div = sh_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign busy_o = sh_q.busy;
    assign fin_o  = fin_c;
    assign sck_o  = sh_q.sck;
    assign mosi_o = sh_q.busy & sh_q.sh[7];

    // R4
    mosi_hold_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $stable(mosi_o));

    // R5
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SCK_DIV     = 2,
    parameter int RST_HOLD_NS = 1000,
    parameter int HK_US       = 1200,
    parameter int ACT_CLKS    = 49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic [7:0] s_data_i,
    input  logic       s_valid_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic       tgt_rst_n_o,
    output logic       tgt_cs_n_o,
    output logic       sck_o,
    output logic       mosi_o,
    input  logic       tgt_done_i
);
    localparam longint RST_CYC_L = ceil_div(longint'(CLK_HZ) * RST_HOLD_NS, 64'd1_000_000_000);
    localparam longint HK_CYC_L  = ceil_div(longint'(CLK_HZ) * HK_US, 64'd1_000_000);
    localparam int     RST_CYC   = (RST_CYC_L < 1) ? 1 : int'(RST_CYC_L);
    localparam int     HK_CYC    = (HK_CYC_L < 1) ? 1 : int'(HK_CYC_L);
    localparam int     MAX_CYC   = (RST_CYC > HK_CYC) ? RST_CYC : HK_CYC;
    localparam int     TW        = $clog2(MAX_CYC + 1);
    localparam int     PAD_BYTES = (ACT_CLKS + 7) / 8;
    localparam int     PW        = $clog2(PAD_BYTES + 1);
    localparam longint SCK_HZ    = longint'(CLK_HZ) / (2 * SCK_DIV);

    generate
        if (SCK_HZ > 64'd25_000_000 || SCK_HZ < 64'd1_000_000) begin : g_sck_range
            $error("serial clock outside 1..25 MHz for CLK_HZ/SCK_DIV");
        end
    endgenerate

    typedef struct packed {
        seq_state_e    st;
        logic          rst_n;
        logic          cs_n;
        logic          busy;
        logic          done;
        logic          err;
        logic          last;
        logic [PW-1:0] pad;
    } seq_t;

    seq_t          q, n;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val;
    logic          sh_load, sh_busy, sh_fin;
    logic [7:0]    sh_data;
    logic          ready_c;

    cfg_wait_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .zero_o (t_zero)
    );

    cfg_spi_shifter #(.DIV(SCK_DIV)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .data_i (sh_data),
        .busy_o (sh_busy),
        .fin_o  (sh_fin),
        .sck_o  (sck_o),
        .mosi_o (mosi_o)
    );

    always_comb begin
        n       = q;
        t_load  = 1'b0;
        t_val   = '0;
        sh_load = 1'b0;
        sh_data = 8'h00;
        ready_c = (q.st == ST_STRM) && !sh_busy && !q.last;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    n.done = 1'b0;
                    if (partial_i) begin
                        n.err = 1'b1;
                    end else begin
                        n.err   = 1'b0;
                        n.st    = ST_RST;
                        n.rst_n = 1'b0;
                        n.cs_n  = 1'b0;
                        n.busy  = 1'b1;
                        n.last  = 1'b0;
                        n.pad   = '0;
                        t_load  = 1'b1;
                        t_val   = TW'(RST_CYC - 1);
                    end
                end
            end
            ST_RST: begin
                if (t_zero) begin
                    n.rst_n = 1'b1;
                    n.st    = ST_CHK;
                end
            end
            ST_CHK: begin
                if (tgt_done_i) begin
                    n.st   = ST_IDLE;
                    n.cs_n = 1'b1;
                    n.busy = 1'b0;
                    n.err  = 1'b1;
                end else begin
                    n.st   = ST_HK;
                    t_load = 1'b1;
                    t_val  = TW'(HK_CYC - 1);
                end
            end
            ST_HK: begin
                if (t_zero) begin
                    n.cs_n = 1'b1;
                    n.st   = ST_GAP;
                end
            end
            ST_GAP: begin
                n.cs_n = 1'b0;
                n.st   = ST_STRM;
            end
            ST_STRM: begin
                if (s_valid_i && ready_c) begin
                    sh_load = 1'b1;
                    sh_data = s_data_i;
                    n.last  = s_last_i;
                end
                if (sh_fin && q.last) begin
                    n.cs_n = 1'b1;
                    n.st   = ST_POST;
                end
            end
            ST_POST: begin
                if (!tgt_done_i) begin
                    n.st   = ST_IDLE;
                    n.busy = 1'b0;
                    n.err  = 1'b1;
                end else begin
                    n.st   = ST_PAD;
                    n.cs_n = 1'b0;
                end
            end
            ST_PAD: begin
                if (!sh_busy) begin
                    sh_load = 1'b1;
                end
                if (sh_fin) begin
                    if (q.pad == PW'(PAD_BYTES - 1)) begin
                        n.st   = ST_IDLE;
                        n.cs_n = 1'b1;
                        n.busy = 1'b0;
                        n.done = 1'b1;
                    end else begin
                        n.pad = q.pad + 1'b1;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.rst_n <= 1'b1;
            q.cs_n  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign s_ready_o   = ready_c;
    assign busy_o      = q.busy;
    assign done_o      = q.done;
    assign err_o       = q.err;
    assign tgt_rst_n_o = q.rst_n;
    assign tgt_cs_n_o  = q.cs_n;

    // R1
    cs_low_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n_o |-> !tgt_cs_n_o);

    // R4
    sck_quiet_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_cs_n_o |-> !sck_o);

    // R8
    partial_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && partial_i && !busy_o |=> err_o && !busy_o && tgt_rst_n_o && tgt_cs_n_o);

    // R9
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o) && !(busy_o && (done_o || err_o)));

    // R9
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !partial_i && !busy_o |=> busy_o && !done_o && !err_o);

    // R5
    ready_outside_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> !tgt_cs_n_o && tgt_rst_n_o && busy_o);

endmodule

// File: tb/tb_fpga_cfg_seq.sv
module tb_fpga_cfg_seq;
    localparam int     CLK_PERIOD = 10;
    localparam int     P_CLK_HZ   = 4_000_000;
    localparam longint RST_EXP    = (longint'(P_CLK_HZ) * 1000 + 999_999_999) / 1_000_000_000;
    localparam longint HK_EXP     = (longint'(P_CLK_HZ) * 1200 + 999_999) / 1_000_000;
    localparam int     WD_LIMIT   = 150_000;

    logic clk = 0, rst_n = 0;
    logic start = 0, partial = 0;
    logic [7:0] s_data = 0;
    logic s_valid = 0, s_last = 0;
    logic s_ready, busy, done, err, tgt_rst_n, tgt_cs_n, sck, mosi, tgt_done;

    int compared = 0, mismatched = 0, cyc = 0;
    logic stuck_hi = 0, good = 1;
    int img_len = 0, cap_n = 0, cap_bits = 0;
    logic [7:0] cap_byte = 0;
    logic [7:0] cap_q[$];
    logic [7:0] exp_q[$];
    logic prev_sck = 0, prev_mosi = 0, prev_rst = 1;
    int rst_run = 0, hk_run = 0;
    logic in_hk = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tgt_done = stuck_hi | (tgt_rst_n && good && img_len > 0 && cap_n >= img_len);

    fpga_cfg_seq #(.CLK_HZ(P_CLK_HZ), .SCK_DIV(1)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .partial_i(partial),
        .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
        .busy_o(busy), .done_o(done), .err_o(err), .tgt_rst_n_o(tgt_rst_n),
        .tgt_cs_n_o(tgt_cs_n), .sck_o(sck), .mosi_o(mosi), .tgt_done_i(tgt_done)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-clock reference of the pin behaviour
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(tgt_cs_n && sck), "R4 sck while cs high", sck, 0);
            chk(!s_ready || (!tgt_cs_n && tgt_rst_n), "R5 ready outside stream", s_ready, 0);
            if (!tgt_rst_n) begin
                rst_run++;
                chk(!tgt_cs_n, "R1 cs low during reset", tgt_cs_n, 0);
            end
            if (tgt_rst_n && !prev_rst) begin
                chk(rst_run == RST_EXP, "R1 reset width", rst_run, RST_EXP);
                chk(!tgt_cs_n, "R1 cs held at reset release", tgt_cs_n, 0);
                rst_run = 0;
                in_hk = 1;
                hk_run = 0;
            end
            if (in_hk) begin
                if (!tgt_cs_n) hk_run++;
                else begin
                    if (!err) chk(hk_run == HK_EXP + 1, "R3 housekeeping width", hk_run, HK_EXP + 1);
                    in_hk = 0;
                end
            end
            if (!tgt_cs_n && sck && !prev_sck) begin
                chk(mosi == prev_mosi, "R4 mosi moved at rising edge", mosi, prev_mosi);
                cap_byte = {cap_byte[6:0], mosi};
                cap_bits++;
                if (cap_bits == 8) begin
                    cap_q.push_back(cap_byte);
                    cap_n++;
                    cap_bits = 0;
                end
            end
            prev_sck  = sck;
            prev_mosi = mosi;
            prev_rst  = tgt_rst_n;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic push(input logic [7:0] d, input logic l, input int gap);
        for (int k = 0; k < gap; k++) begin
            s_valid = 0;
            @(negedge clk);
        end
        s_data = d; s_last = l; s_valid = 1;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        chk(!s_ready, "R5 ready low after accept", s_ready, 0);
        s_valid = 0; s_last = 0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 30000) begin
            @(negedge clk);
            t++;
        end
        chk(!busy, "R9 run finished", busy, 0);
    endtask

    task automatic pulse_start(input logic part);
        @(negedge clk);
        start = 1; partial = part;
        @(negedge clk);
        start = 0; partial = 0;
    endtask

    task automatic run(input int n, input int gap, input logic good_v, input logic stuck_v, input logic restart);
        cap_q.delete(); exp_q.delete();
        cap_n = 0; cap_bits = 0; img_len = n;
        good = good_v; stuck_hi = stuck_v;
        pulse_start(0);
        chk(busy && !done && !err, "R9 start clears status", {busy, done, err}, 3'b100);
        if (stuck_v) begin
            wait_idle();
            chk(err && !done, "R2 error on stuck done line", err, 1);
            chk(cap_q.size() == 0, "R2 no clocks after failed reset", cap_q.size(), 0);
            chk(tgt_cs_n && tgt_rst_n, "R2 pins released", {tgt_cs_n, tgt_rst_n}, 2'b11);
        end else begin
            if (restart) begin
                repeat (60) @(negedge clk);
                start = 1;
                @(negedge clk);
                start = 0;
                chk(busy && !err, "R9 start while busy ignored", busy, 1);
            end
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = 8'hA5 ^ 8'(i * 37 + n);
                exp_q.push_back(b);
                push(b, i == n - 1, gap);
            end
            wait_idle();
            if (good_v) begin
                for (int i = 0; i < 7; i++) exp_q.push_back(8'h00);
                chk(done && !err, "R7 done after activation", done, 1);
                chk(cap_q.size() == n + 7, "R7 pad byte count", cap_q.size(), n + 7);
            end else begin
                chk(err && !done, "R6 error on missing done", err, 1);
                chk(cap_q.size() == n, "R6 no activation clocks", cap_q.size(), n);
            end
            for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
                chk(cap_q[i] == exp_q[i], "R5 R7 serial byte", cap_q[i], exp_q[i]);
            chk(tgt_cs_n && !sck, "R4 idle after run", {tgt_cs_n, sck}, 2'b10);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(tgt_rst_n && tgt_cs_n, "R10 target pins at reset", {tgt_rst_n, tgt_cs_n}, 2'b11);
        chk(!sck && !mosi && !s_ready, "R10 serial/ready at reset", {sck, mosi, s_ready}, 0);
        chk(!busy && !done && !err, "R10 status at reset", {busy, done, err}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R8 partial reject
        pulse_start(1);
        chk(err && !busy, "R8 partial rejected", {err, busy}, 2'b10);
        chk(tgt_rst_n && tgt_cs_n, "R8 pins untouched", {tgt_rst_n, tgt_cs_n}, 2'b11);
        repeat (5) @(negedge clk);
        chk(cap_q.size() == 0 && !sck, "R8 no clocks", sck, 0);

        run(5, 2, 1, 0, 1);
        repeat (30) @(negedge clk);
        chk(done && !busy, "R9 done held", done, 1);

        run(4, 0, 1, 0, 0);
        run(0, 0, 1, 1, 0);
        run(3, 1, 0, 0, 0);
        repeat (10) @(negedge clk);
        chk(err && !done, "R9 err held", err, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule